// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software through a timer that has to be restarted at regular intervals. Software programs one 8-bit control and status register through a plain write strobe with data and reads it back through a combinational read bus. Once either stage is enabled, the timer counts timebase ticks. The ticks come from a prescaler of parameterised length, where one tick stands for a quarter second. The count is compared against one of eight terminal counts. A pulse on `strobe` restarts the countdown.

When the first countdown runs out, the block sets a status bit. If the first stage is enabled, it also emits a one-clock pulse on either the NMI output or the INIT output, as a mode bit selects. The timer then starts a second countdown of the same length. If that one also runs out with the second stage enabled, the block drives `hard_rst_out` for a fixed number of clocks. It clears its own control state and sets a sticky cause flag. That flag survives the watchdog's own reset. Only power-on reset or the external hard-reset request `hrst_in` clears it.

Top module: `wdt_two_stage`

## Requirements
- R1: After `por_n` or a one-cycle `hrst_in`, the register reads 0x00 and `nmi_pulse`, `init_pulse` and `hard_rst_out` are low.
- R2: Bits [5:0] of the register (terminal count [2:0], action select [3], first-stage enable [4], second-stage enable [5]) read back the value last written while no watchdog reset is in progress.
- R3: Terminal count codes 0 to 7 select 1, 2, 4, 8, 32, 128, 512 and 1024 ticks of `TICK_CLKS` clocks each. A countdown started by the edge that samples a strobe or an enabling write expires exactly ticks*TICK_CLKS edges later. The first-stage pulse is visible in the cycle after that edge.
- R4: At first-stage expiry with bit 4 set, bit 3 = 0 gives a single-clock `nmi_pulse` and bit 3 = 1 gives a single-clock `init_pulse`. The pulse does not repeat until the next first-stage expiry.
- R5: With bit 4 clear, a first-stage expiry produces neither pulse.
- R6: Bit 6 (mask 0x40) becomes 1 at every first-stage expiry. Writing 0 to it clears it and restarts the first-stage countdown. Writing 1 to it has no effect.
- R7: A `strobe` restarts the countdown in the first stage, including when the second stage is already counting. This prevents the hard reset.
- R8: With bit 5 set, if the second countdown (one more full period) expires, `hard_rst_out` is high for `RST_CYCLES` consecutive clocks. Bits [6:0] become 0 and bit 7 becomes 1 in the same cycle.
- R9: Bit 7 ignores writes and stays 1 through the watchdog's own reset. It is cleared only by `por_n` or `hrst_in`.
- R10: A write that changes the terminal count restarts the countdown with the new count.
- R11: With bits 4 and 5 both clear the timer does not run: no pulse and no status change.
- R12: While `hard_rst_out` is high, register writes and strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| hrst_in | input | 1 | Synchronous hard-reset request from other sources, clears everything |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| strobe | input | 1 | Restart pulse from software |
| nmi_pulse | output | 1 | One-clock first-stage NMI request |
| init_pulse | output | 1 | One-clock first-stage INIT request |
| hard_rst_out | output | 1 | Second-stage hard reset, RST_CYCLES clocks long |

## Verification
The hardest state to reach is a second-stage timeout that fires after strobes have already been accepted at both stages. Only then does the bench show that a late strobe, arriving after the first pulse, still prevents the reset. The stimulus enables both stages with a short terminal count and counts edges from the enabling write. It strobes once during the first countdown and once during the second, then lets the timer run out. The bench then writes and strobes during the reset pulse and reads back 0x80. A separate pass with only the second stage enabled shows the status bit rising without any pulse before the reset fires.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int MAX_TICKS = 1024;
    localparam int CNT_W     = $clog2(MAX_TICKS) + 1;

    typedef struct packed {
        logic [2:0] tc;
        logic       sel_init;
        logic       s1_en;
        logic       s2_en;
        logic       s1_stat;
        logic       flag;
        logic       stage2;
        logic       nmi;
        logic       init;
    } ctl_t;

    function automatic logic [CNT_W-1:0] tc_ticks(input logic [2:0] code);
        logic [CNT_W-1:0] r;
        case (code)
            3'd0:    r = CNT_W'(1);
            3'd1:    r = CNT_W'(2);
            3'd2:    r = CNT_W'(4);
            3'd3:    r = CNT_W'(8);
            3'd4:    r = CNT_W'(32);
            3'd5:    r = CNT_W'(128);
            3'd6:    r = CNT_W'(512);
            default: r = CNT_W'(1024);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int TICK_CLKS = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic clr,
    output logic tick
);
    generate
        if (TICK_CLKS <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_count
            localparam int PW = $clog2(TICK_CLKS);
            localparam logic [PW-1:0] LAST = PW'(TICK_CLKS - 1);
            logic [PW-1:0] pre_d, pre_q;

            always_comb begin
                pre_d = pre_q;
                if (clr || pre_q == LAST) pre_d = '0;
                else                      pre_d = pre_q + 1'b1;
            end

            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end

            assign tick = (pre_q == LAST);

            p_pre_range_r3: assert property (@(posedge clk) disable iff (!por_n)
                pre_q <= LAST);
        end
    endgenerate
endmodule

// File: rtl/wdt_stage_ctr.sv
module wdt_stage_ctr
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             at_last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_last = (cnt_q == limit - 1'b1);

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!por_n)
        cnt_q < limit);
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic clr,
    input  logic fire,
    output logic active
);
    localparam int RW = $clog2(RST_CYCLES + 1);
    logic [RW-1:0] rc_d, rc_q;

    always_comb begin
        rc_d = rc_q;
        if (clr)               rc_d = '0;
        else if (fire)         rc_d = RW'(RST_CYCLES);
        else if (rc_q != '0)   rc_d = rc_q - 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) rc_q <= '0;
        else        rc_q <= rc_d;
    end

    assign active = (rc_q != '0);

    p_len_bound_r8: assert property (@(posedge clk) disable iff (!por_n)
        rc_q <= RW'(RST_CYCLES));
    p_no_refire_r8: assert property (@(posedge clk) disable iff (!por_n)
        (active && !clr) |=> !$rose(rc_q == RW'(RST_CYCLES)));
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int TICK_CLKS  = 4,
    parameter int RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       hrst_in,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       strobe,
    output logic       nmi_pulse,
    output logic       init_pulse,
    output logic       hard_rst_out
);
    ctl_t q, d;
    logic tick, at_last, busy;
    logic wr_ok, stb_ok, tc_chg, clr_s1, running, expire, restart, fire;
    logic wr_unused;

    assign wr_unused = wr_data[7];

    always_comb begin
        wr_ok   = wr_en && !busy;
        stb_ok  = strobe && !busy;
        tc_chg  = wr_ok && (wr_data[2:0] != q.tc);
        clr_s1  = wr_ok && !wr_data[6];
        running = (q.s1_en || q.s2_en) && !busy;
        expire  = running && tick && at_last && !stb_ok && !tc_chg && !clr_s1;
        fire    = expire && q.stage2 && q.s2_en && !hrst_in;
        restart = !running || stb_ok || tc_chg || clr_s1 || expire || hrst_in;

        d      = q;
        d.nmi  = 1'b0;
        d.init = 1'b0;
        if (wr_ok) begin
            d.tc       = wr_data[2:0];
            d.sel_init = wr_data[3];
            d.s1_en    = wr_data[4];
            d.s2_en    = wr_data[5];
            if (clr_s1) begin
                d.s1_stat = 1'b0;
                d.stage2  = 1'b0;
            end
        end
        if (stb_ok) d.stage2 = 1'b0;
        if (expire) begin
            if (!q.stage2) begin
                d.s1_stat = 1'b1;
                d.stage2  = 1'b1;
                d.nmi     = q.s1_en && !q.sel_init;
                d.init    = q.s1_en && q.sel_init;
            end else if (q.s2_en) begin
                d      = '0;
                d.flag = 1'b1;
            end
        end
        if (hrst_in) d = '0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q <= '0;
        else        q <= d;
    end

    wdt_prescaler #(.TICK_CLKS(TICK_CLKS)) u_pre (
        .clk  (clk),
        .por_n(por_n),
        .clr  (restart),
        .tick (tick)
    );

    wdt_stage_ctr u_ctr (
        .clk    (clk),
        .por_n  (por_n),
        .clr    (restart),
        .tick   (tick),
        .limit  (tc_ticks(q.tc)),
        .at_last(at_last)
    );

    wdt_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk   (clk),
        .por_n (por_n),
        .clr   (hrst_in),
        .fire  (fire),
        .active(busy)
    );

    assign rd_data      = {q.flag, q.s1_stat, q.s2_en, q.s1_en, q.sel_init, q.tc};
    assign nmi_pulse    = q.nmi;
    assign init_pulse   = q.init;
    assign hard_rst_out = busy;

    p_one_kind_r4: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({nmi_pulse, init_pulse}));
    p_single_nmi_r4: assert property (@(posedge clk) disable iff (!por_n)
        nmi_pulse |=> !nmi_pulse);
    p_single_init_r4: assert property (@(posedge clk) disable iff (!por_n)
        init_pulse |=> !init_pulse);
    p_pulse_sets_stat_r6: assert property (@(posedge clk) disable iff (!por_n)
        (nmi_pulse || init_pulse) |-> rd_data[6]);
    p_rst_sets_flag_r8: assert property (@(posedge clk) disable iff (!por_n)
        hard_rst_out |-> (rd_data == 8'h80));
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
        (rd_data[7] && !hrst_in) |=> rd_data[7]);
    p_readback_r2: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !hard_rst_out && !hrst_in && !fire) |=> (rd_data[5:0] == $past(wr_data[5:0])));
    p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!por_n)
        (hard_rst_out && !hrst_in) |=> $stable(rd_data));
endmodule

// File: tb/sim_wdt_two_stage.sv
module sim_wdt_two_stage;
    localparam int TICK = 4;
    localparam int RSTN = 16;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic hrst_in = 1'b0, wr_en = 1'b0, strobe = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic nmi_pulse, init_pulse, hard_rst_out;

    int cyc = 0;
    int tests = 0;
    int fails = 0;
    bit mon_on = 1'b0;

    typedef struct {
        int    at;
        int    len;
        int    kind;
        string req;
    } exp_t;
    exp_t expq[$];

    always #4 clk = ~clk;

    wdt_two_stage #(.TICK_CLKS(TICK), .RST_CYCLES(RSTN)) u0 (
        .clk(clk), .por_n(por_n), .hrst_in(hrst_in), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .strobe(strobe),
        .nmi_pulse(nmi_pulse), .init_pulse(init_pulse), .hard_rst_out(hard_rst_out)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ticks_of(input int c);
        int t[8] = '{1, 2, 4, 8, 32, 128, 512, 1024};
        return t[c];
    endfunction

    // Monitor: pops expected pulses and compares every cycle
    always @(negedge clk) begin
        if (mon_on) begin
            logic [2:0] want;
            logic [2:0] got;
            string      rq;
            bit         start;
            want  = 3'b000;
            rq    = "R4 quiet";
            start = 1'b0;
            foreach (expq[i]) begin
                if (cyc >= expq[i].at && cyc < expq[i].at + expq[i].len) begin
                    want[expq[i].kind] = 1'b1;
                    rq = expq[i].req;
                    if (cyc == expq[i].at) start = 1'b1;
                end
            end
            got = {hard_rst_out, init_pulse, nmi_pulse};
            if (got != want) begin
                tests++;
                fails++;
                $display("FAIL %s cyc=%0d {rst,init,nmi} actual=%b expected=%b", rq, cyc, got, want);
            end else if (start) begin
                tests++;
            end
            while (expq.size() > 0 && expq[0].at + expq[0].len - 1 <= cyc)
                void'(expq.pop_front());
        end
    end

    task automatic push(input int at, input int len, input int kind, input string req);
        exp_t e;
        e.at = at; e.len = len; e.kind = kind; e.req = req;
        expq.push_back(e);
    endtask

    task automatic goto(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] v);
        wr_data = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_strobe();
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic do_hrst();
        hrst_in = 1'b1;
        @(negedge clk);
        hrst_in = 1'b0;
    endtask

    task automatic chk_rd(input logic [7:0] e, input string req);
        tests++;
        if (rd_data !== e) begin
            fails++;
            $display("FAIL %s rd_data actual=%h expected=%h", req, rd_data, e);
        end
    endtask

    task automatic chk_quiet(input string req);
        tests++;
        if ({hard_rst_out, init_pulse, nmi_pulse} !== 3'b000) begin
            fails++;
            $display("FAIL %s outputs actual=%b expected=000", req, {hard_rst_out, init_pulse, nmi_pulse});
        end
    endtask

    initial begin
        int e0;
        int s;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        chk_rd(8'h00, "R1");
        chk_quiet("R1");
        mon_on = 1'b1;

        // R2 / R6 / R9: readback, bit6 and bit7 ignore writes of 1
        do_write(8'h05);
        chk_rd(8'h05, "R2");
        do_write(8'hC7);
        chk_rd(8'h07, "R2 R6 R9");
        // R11: disabled timer stays idle over a whole longest period
        goto(cyc + 1100 * TICK);
        chk_rd(8'h07, "R11");

        // R3 / R4: every terminal count, alternating NMI and INIT
        for (int c = 0; c < 8; c++) begin
            logic [7:0] w;
            do_hrst();
            chk_rd(8'h00, "R1");
            w = 8'h10 | (c[0] ? 8'h08 : 8'h00) | 8'(c);
            do_write(w);
            e0 = cyc;
            push(e0 + TICK * ticks_of(c), 1, c[0] ? 1 : 0, "R3 R4");
            goto(e0 + TICK * ticks_of(c) + 2);
            chk_rd(w | 8'h40, "R6");
        end

        // R5 / R8 / R9 / R12: second stage only
        do_hrst();
        do_write(8'h21);
        e0 = cyc;
        push(e0 + 16, RSTN, 2, "R8");
        goto(e0 + 10);
        chk_rd(8'h61, "R5 R6");
        goto(e0 + 20);
        do_write(8'h13);
        do_strobe();
        goto(e0 + 16 + RSTN + 2);
        chk_rd(8'h80, "R8 R9 R12");
        goto(cyc + 40);
        chk_rd(8'h80, "R9 R12");
        do_write(8'hC0);
        chk_rd(8'h80, "R9");
        do_hrst();
        chk_rd(8'h00, "R9");

        // R7: strobes in both stages, then let it run out
        do_write(8'h31);
        e0 = cyc;
        goto(e0 + 4);
        do_strobe();
        s = cyc;
        push(s + 8, 1, 0, "R7");
        goto(s + 12);
        do_strobe();
        s = cyc;
        push(s + 8, 1, 0, "R7");
        push(s + 16, RSTN, 2, "R7 R8");
        goto(s + 16 + RSTN + 2);
        chk_rd(8'h80, "R8");

        // R10: change terminal count mid-count
        do_hrst();
        do_write(8'h12);
        e0 = cyc;
        goto(e0 + 9);
        do_write(8'h13);
        s = cyc;
        push(s + 32, 1, 0, "R10");
        goto(s + 34);
        chk_rd(8'h53, "R10 R6");

        // R6: clearing status restarts first stage; R4 no repeat
        goto(s + 50);
        do_write(8'h13);
        s = cyc;
        chk_rd(8'h13, "R6");
        push(s + 32, 1, 0, "R6");
        goto(s + 32 + 20);
        chk_rd(8'h53, "R6");
        goto(s + 32 + 30);
        chk_quiet("R4");

        do_hrst();
        goto(cyc + 4);
        mon_on = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule